// File: doc/BRIEF.md
# Failing Sector Capture Logger

This block follows a signature-checking engine as it walks through the sectors of a memory block. It records the number of a sector of interest. A sector counter starts at zero when a block begins and advances once for each sector-complete pulse. It wraps to zero after the last sector of the block. Software sets the number of sectors per block through a 16-bit preload register.

In automatic mode, a signature mismatch copies the current sector number into a read-only capture register and raises a sticky fail interrupt. The capture register then stays frozen until the CPU has both read it and cleared the fail flag, in either order. A mismatch that arrives while the register is frozen does not overwrite the stored number. It raises a sticky overrun interrupt instead. In semi-CPU mode, the capture register instead follows the sector number of the most recent sector-complete pulse, and mismatches are ignored.

The CPU side has three accesses: a write strobe for the preload, a read strobe for the capture register, and a flag-clear write. The flag-clear write is write-one-to-clear, with bit 0 for the fail flag and bit 1 for the overrun flag. Both CPU-visible registers are 32 bits wide, and their upper 16 bits always read as zero.

Top module: `fail_sector_logger`

## Requirements
- R1: While `rst` is high on a clock edge, the preload, the sector counter, the captured sector ID and both interrupt flags become 0.
- R2: A preload write stores bits 15:0 of `preload_wdata`. `preload_rdata` returns that value in bits 15:0 and zero in bits 31:16, and written upper bits have no effect. Without a write, the preload holds.
- R3: The sector counter is set to 0 by `block_start`, which has priority over `sector_done`. On `sector_done` the counter advances by one. When the preload P is not 0 and the counter equals P−1, it goes to 0 instead. When P is 0, it wraps at 65535.
- R4: In automatic mode (`mode`=1), a `sig_mismatch` when no capture is frozen loads the current counter value into the captured ID and sets `fail_irq` on the next cycle.
- R5: A `sig_mismatch` while frozen leaves the captured ID unchanged and sets `ovr_irq` instead of a new capture.
- R6: The freeze ends only after both a `secid_rd` strobe and a fail-flag clear have happened since the capture, in either order. One of them alone keeps the register frozen.
- R7: A `sig_mismatch` in the same cycle as the second of the two release events is captured as a fresh fail: the ID is loaded, `fail_irq` is set and `ovr_irq` is not set.
- R8: In semi-CPU mode (`mode`=0), each `sector_done` loads the counter value before the advance into the captured ID. In this mode `sig_mismatch` sets no interrupt.
- R9: A flag-clear write with bit 0 set clears `fail_irq`, and with bit 1 set clears `ovr_irq`. A set event in the same cycle wins over the clear. Otherwise both flags stay set.
- R10: `secid_rdata` carries the captured ID in bits 15:0 and zero in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 1 = automatic check, 0 = semi-CPU |
| block_start | input | 1 | Restarts the sector counter at 0 |
| sector_done | input | 1 | One-cycle pulse per completed sector |
| sig_mismatch | input | 1 | One-cycle pulse: current sector's signature failed |
| preload_wr | input | 1 | Preload write strobe |
| preload_wdata | input | 32 | Preload write data (bits 15:0 used) |
| preload_rdata | output | 32 | Preload readback |
| secid_rd | input | 1 | Read strobe of the captured sector register |
| flag_clr_wr | input | 1 | Flag-clear write strobe |
| flag_clr_data | input | 2 | Write-one-to-clear mask: bit 0 fail, bit 1 overrun |
| secid_rdata | output | 32 | Captured sector ID readback |
| fail_irq | output | 1 | Sticky fail interrupt |
| ovr_irq | output | 1 | Sticky overrun interrupt |

## Verification
The assertions assume that `mode` changes only while no capture is frozen. Under that assumption, the freeze state and the interrupt flags describe a single mode's history. The assertions also assume that strobes are sampled as single-cycle events on clock edges. The random stimulus flips `mode` only when the bench's own model shows no frozen capture. It keeps preload values small, so that wrap-around occurs often. Directed sequences cover the release-order and same-cycle cases.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic {
    MODE_SEMI = 1'b0,
    MODE_AUTO = 1'b1
  } op_mode_e;

  localparam int FLAG_FAIL_BIT = 0;
  localparam int FLAG_OVR_BIT  = 1;
endpackage

// File: rtl/fsl_sector_counter.sv
module fsl_sector_counter #(
  parameter int SEC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             block_start,
  input  logic             sector_done,
  input  logic [SEC_W-1:0] preload,
  output logic [SEC_W-1:0] cnt
);
  localparam logic [SEC_W-1:0] ONE = SEC_W'(1);

  logic at_last;
  assign at_last = (preload != '0) && (cnt == preload - ONE);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (block_start) cnt <= '0;
    else if (sector_done) cnt <= at_last ? '0 : cnt + ONE;
  end

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sector_done && !block_start && preload != '0 && cnt == preload - ONE) |=> cnt == '0);

  // R3
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    block_start |=> cnt == '0);
endmodule

// File: rtl/fsl_capture_ctrl.sv
module fsl_capture_ctrl
  import fsl_pkg::*;
#(
  parameter int SEC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  op_mode_e         mode,
  input  logic             sector_done,
  input  logic             sig_mismatch,
  input  logic [SEC_W-1:0] cnt,
  input  logic             secid_rd,
  input  logic             clr_fail,
  input  logic             clr_ovr,
  output logic [SEC_W-1:0] secid,
  output logic             fail_irq,
  output logic             ovr_irq
);
  logic frozen, rd_seen, clr_seen;
  logic rd_ok, clr_ok, release_now, open_now, auto_m, take, lost;

  always_comb begin
    auto_m      = (mode == MODE_AUTO);
    rd_ok       = rd_seen | secid_rd;
    clr_ok      = clr_seen | clr_fail;
    release_now = frozen & rd_ok & clr_ok;
    open_now    = ~frozen | release_now;
    take        = auto_m & sig_mismatch & open_now;
    lost        = auto_m & sig_mismatch & ~open_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      secid    <= '0;
      frozen   <= 1'b0;
      rd_seen  <= 1'b0;
      clr_seen <= 1'b0;
      fail_irq <= 1'b0;
      ovr_irq  <= 1'b0;
    end else begin
      if (take)                        secid <= cnt;
      else if (!auto_m && sector_done) secid <= cnt;

      if (take)             frozen <= 1'b1;
      else if (release_now) frozen <= 1'b0;

      if (take || release_now)       rd_seen <= 1'b0;
      else if (frozen && secid_rd)   rd_seen <= 1'b1;

      if (take || release_now)       clr_seen <= 1'b0;
      else if (frozen && clr_fail)   clr_seen <= 1'b1;

      if (take)          fail_irq <= 1'b1;
      else if (clr_fail) fail_irq <= 1'b0;

      if (lost)         ovr_irq <= 1'b1;
      else if (clr_ovr) ovr_irq <= 1'b0;
    end
  end

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_m && sig_mismatch && !frozen) |=> (fail_irq && secid == $past(cnt)));

  // R5
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_m && sig_mismatch && frozen && !(rd_ok && clr_ok)) |=> ($stable(secid) && ovr_irq));

  // R7
  fresh_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_m && sig_mismatch && frozen && rd_ok && clr_ok && !ovr_irq && !clr_ovr)
      |=> (fail_irq && !ovr_irq));

  // R8
  semi_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_m && !fail_irq && !ovr_irq) |=> (!fail_irq && !ovr_irq));

  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ovr && !(auto_m && sig_mismatch && frozen)) |=> !ovr_irq);
endmodule

// File: rtl/fail_sector_logger.sv
module fail_sector_logger
  import fsl_pkg::*;
#(
  parameter int SEC_W = 16,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             block_start,
  input  logic             sector_done,
  input  logic             sig_mismatch,
  input  logic             preload_wr,
  input  logic [BUS_W-1:0] preload_wdata,
  output logic [BUS_W-1:0] preload_rdata,
  input  logic             secid_rd,
  input  logic             flag_clr_wr,
  input  logic [1:0]       flag_clr_data,
  output logic [BUS_W-1:0] secid_rdata,
  output logic             fail_irq,
  output logic             ovr_irq
);
  localparam int PAD_W = BUS_W - SEC_W;

  logic [SEC_W-1:0] preload, cnt, secid;
  logic clr_fail, clr_ovr;

  always_ff @(posedge clk) begin
    if (rst)             preload <= '0;
    else if (preload_wr) preload <= preload_wdata[SEC_W-1:0];
  end

  assign clr_fail      = flag_clr_wr & flag_clr_data[FLAG_FAIL_BIT];
  assign clr_ovr       = flag_clr_wr & flag_clr_data[FLAG_OVR_BIT];
  assign preload_rdata = {{PAD_W{1'b0}}, preload};
  assign secid_rdata   = {{PAD_W{1'b0}}, secid};

  fsl_sector_counter #(.SEC_W(SEC_W)) cnt_i (
    .clk         (clk),
    .rst         (rst),
    .block_start (block_start),
    .sector_done (sector_done),
    .preload     (preload),
    .cnt         (cnt)
  );

  fsl_capture_ctrl #(.SEC_W(SEC_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .mode         (op_mode_e'(mode)),
    .sector_done  (sector_done),
    .sig_mismatch (sig_mismatch),
    .cnt          (cnt),
    .secid_rd     (secid_rd),
    .clr_fail     (clr_fail),
    .clr_ovr      (clr_ovr),
    .secid        (secid),
    .fail_irq     (fail_irq),
    .ovr_irq      (ovr_irq)
  );

  // R2
  preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !preload_wr |=> $stable(preload_rdata));
endmodule

// File: tb/fail_sector_logger_tb_top.sv
module fail_sector_logger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst, mode, block_start, sector_done, sig_mismatch;
  logic preload_wr, secid_rd, flag_clr_wr;
  logic [31:0] preload_wdata, preload_rdata, secid_rdata;
  logic [1:0]  flag_clr_data;
  logic fail_irq, ovr_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  logic [15:0] m_pre, m_cnt, m_id;
  logic m_fail, m_ovr, m_frz, m_rd, m_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fail_sector_logger dut_i (
    .clk(clk), .rst(rst), .mode(mode), .block_start(block_start),
    .sector_done(sector_done), .sig_mismatch(sig_mismatch),
    .preload_wr(preload_wr), .preload_wdata(preload_wdata),
    .preload_rdata(preload_rdata), .secid_rd(secid_rd),
    .flag_clr_wr(flag_clr_wr), .flag_clr_data(flag_clr_data),
    .secid_rdata(secid_rdata), .fail_irq(fail_irq), .ovr_irq(ovr_irq)
  );

  function automatic logic [15:0] next_cnt(logic [15:0] c, logic [15:0] p, logic bs, logic sd);
    if (bs) return 16'd0;
    if (!sd) return c;
    if (p != 16'd0 && c == p - 16'd1) return 16'd0;
    return c + 16'd1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " secid"},   secid_rdata,   {16'd0, m_id});
    check({tag, " preload"}, preload_rdata, {16'd0, m_pre});
    check({tag, " irq"},     {30'd0, ovr_irq, fail_irq}, {30'd0, m_ovr, m_fail});
  endtask

  task automatic step(input string tag, input logic bs, input logic sd, input logic mm,
                      input logic rd, input logic cw, input logic [1:0] cd,
                      input logic pw, input logic [31:0] pd, input logic md);
    logic cf, co, rel, take, lost, auto_m;
    @(negedge clk);
    block_start = bs; sector_done = sd; sig_mismatch = mm; secid_rd = rd;
    flag_clr_wr = cw; flag_clr_data = cd; preload_wr = pw; preload_wdata = pd; mode = md;
    auto_m = md;
    cf   = cw & cd[0];
    co   = cw & cd[1];
    rel  = m_frz & (m_rd | rd) & (m_clr | cf);
    take = auto_m & mm & (~m_frz | rel);
    lost = auto_m & mm & m_frz & ~rel;
    @(posedge clk);
    #1;
    if (take) m_id = m_cnt;
    else if (!auto_m && sd) m_id = m_cnt;
    if (take || rel) begin m_rd = 1'b0; m_clr = 1'b0; end
    else begin
      if (m_frz && rd) m_rd = 1'b1;
      if (m_frz && cf) m_clr = 1'b1;
    end
    if (take) m_frz = 1'b1; else if (rel) m_frz = 1'b0;
    if (take) m_fail = 1'b1; else if (cf) m_fail = 1'b0;
    if (lost) m_ovr = 1'b1; else if (co) m_ovr = 1'b0;
    m_cnt = next_cnt(m_cnt, m_pre, bs, sd);
    if (pw) m_pre = pd[15:0];
    compare_all(tag);
  endtask

  task automatic idle(input string tag, input logic md);
    step(tag, 0, 0, 0, 0, 0, 2'b00, 0, 32'd0, md);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; mode = 1'b0; block_start = 0; sector_done = 0; sig_mismatch = 0;
    preload_wr = 0; preload_wdata = '0; secid_rd = 0; flag_clr_wr = 0; flag_clr_data = '0;
    m_pre = 0; m_cnt = 0; m_id = 0; m_fail = 0; m_ovr = 0; m_frz = 0; m_rd = 0; m_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    compare_all("R1 reset");

    // R2: upper bits ignored
    step("R2 preload", 0, 0, 0, 0, 0, 2'b00, 1, 32'hABCD_0005, 0);
    check("R2 upper zero", {16'd0, preload_rdata[31:16]}, 32'd0);

    // R3, R8: semi mode follows sector, wraps after 4 (preload 5)
    for (int i = 0; i < 7; i++) step("R3 R8 semi count", 0, 1, 0, 0, 0, 2'b00, 0, 0, 0);
    check("R3 wrap value", secid_rdata, 32'd1);
    // R8: mismatch ignored in semi mode
    step("R8 semi mismatch", 0, 0, 1, 0, 0, 2'b00, 0, 0, 0);
    check("R8 no irq", {30'd0, ovr_irq, fail_irq}, 32'd0);
    // R3: block_start beats sector_done
    step("R3 start", 1, 1, 0, 0, 0, 2'b00, 0, 0, 0);
    step("R3 after start", 0, 1, 0, 0, 0, 2'b00, 0, 0, 0);
    check("R3 restart id", secid_rdata, 32'd0);
    step("R3 advance", 0, 1, 0, 0, 0, 2'b00, 0, 0, 1);

    // R4: capture in automatic mode (counter now 2)
    step("R4 capture", 0, 0, 1, 0, 0, 2'b00, 0, 0, 1);
    check("R4 id", secid_rdata, 32'd2);
    check("R4 fail", {31'd0, fail_irq}, 32'd1);
    step("R4 move", 0, 1, 0, 0, 0, 2'b00, 0, 0, 1);
    // R5: frozen mismatch -> overrun
    step("R5 frozen", 0, 0, 1, 0, 0, 2'b00, 0, 0, 1);
    check("R5 id kept", secid_rdata, 32'd2);
    check("R5 ovr", {31'd0, ovr_irq}, 32'd1);
    // R6: read alone keeps freeze
    step("R6 read", 0, 0, 0, 1, 0, 2'b00, 0, 0, 1);
    step("R6 read only", 0, 0, 1, 0, 0, 2'b00, 0, 0, 1);
    check("R6 still frozen", secid_rdata, 32'd2);
    // R9: clear overrun loses to a same-cycle overrun
    step("R9 set wins", 0, 0, 1, 0, 1, 2'b10, 0, 0, 1);
    check("R9 ovr kept", {31'd0, ovr_irq}, 32'd1);
    step("R9 clr ovr", 0, 0, 0, 0, 1, 2'b10, 0, 0, 1);
    check("R9 ovr cleared", {31'd0, ovr_irq}, 32'd0);
    // R7: clear fail with mismatch in same cycle (read already seen)
    step("R7 fresh", 0, 0, 1, 0, 1, 2'b01, 0, 0, 1);
    check("R7 id", secid_rdata, 32'd3);
    check("R7 fail", {30'd0, ovr_irq, fail_irq}, 32'd1);
    // R6: other order, clear first then read
    step("R6 clr", 0, 1, 0, 0, 1, 2'b01, 0, 0, 1);
    step("R6 clr only", 0, 0, 1, 0, 0, 2'b00, 0, 0, 1);
    check("R6 held", secid_rdata, 32'd3);
    step("R6 read second", 0, 0, 0, 1, 1, 2'b11, 0, 0, 1);
    step("R6 released", 0, 0, 1, 0, 0, 2'b00, 0, 0, 1);
    check("R6 new id", secid_rdata, 32'd4);
    check("R10 upper", {16'd0, secid_rdata[31:16]}, 32'd0);
    step("R9 clr both", 0, 0, 0, 1, 1, 2'b11, 0, 0, 1);
    check("R9 both clear", {30'd0, ovr_irq, fail_irq}, 32'd0);

    // random phase covering R2..R10
    for (int i = 0; i < 4000; i++) begin
      logic md;
      logic [31:0] pd;
      md = mode;
      if (!m_frz && ($urandom % 40) == 0) md = ~mode;
      pd = {$urandom % 65536, 16'd0} | (($urandom % 8 == 0) ? 32'd0 : 32'd1 + ($urandom % 6));
      step("R2..R10 random", ($urandom % 30) == 0, ($urandom % 3) == 0,
           ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           2'($urandom % 4), ($urandom % 50) == 0, pd, md);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule